// File: doc/BRIEF.md
# Protected RTC Register Commit Unit

This unit is the bus-facing control layer of a real-time clock. Software writes land in shadow (staging) registers. They reach the calendar and alarm logic only when software writes the trigger register. A commit then runs for a fixed number of cycles, and a busy flag is visible in the control register for that whole time. When the commit completes, the staged values are transferred together.

Two mechanisms guard the clock. A write-protection register must see two magic words, each committed in turn, before commits may change the time and alarm values. A pair of power-valid key registers decides whether the clock is in normal mode or has lost power. The keys are only taken by a commit once the two configuration registers have been committed.

The calendar counter and the alarm comparator sit outside this unit. The unit drives them with committed values and a load strobe, and returns the calendar's live time on reads.

Top module: `rtc_commit_unit`

## Requirements
- R1: A write to offset 0x78 with data bit 0 set starts a commit when no commit is running. Such a write with bit 0 clear, or one made while a commit is running, starts nothing.
- R2: `busy_o`, and bit 6 of a read at offset 0x00, are 1 for exactly COMMIT_CYCLES cycles, starting the cycle after the accepted trigger write.
- R3: Staged values are transferred on the clock edge that ends a commit. If a staging write lands on that same edge, the commit transfers the value held before the write, and the new value waits for the next commit.
- R4: The unit unlocks when a commit completes with protection word 0x9136 written at offset 0x70, followed by a later commit that completes with 0x586a written there. `unlocked_o` then reads 1.
- R5: A commit that completes with any other value written to offset 0x70 returns the unit to locked. So does 0x586a without a preceding 0x9136. A commit with no write to offset 0x70 leaves the protection state unchanged.
- R6: A commit that completes while locked leaves `time_o` and `alarm_o` unchanged. A commit that completes while unlocked copies the staged time and alarm, and `time_load_o` is 1 for the one cycle in which the new `time_o` first appears. `time_o` changes at no other time.
- R7: `power_lost_o` is 1 after reset. It becomes 0 only when a commit completes with 0xa357 staged at offset 0x4c and 0x67d2 staged at offset 0x50. The keys are taken only if both configuration registers (offsets 0x5c and 0x60) were written and committed by an earlier commit.
- R8: A write to offset 0x00 takes effect only if bits 15:8 hold 0x43. Bit 5 then gives a one-cycle `reload_o` pulse on the next cycle. Bit 4 clears both key registers, which wins over a commit that completes on the same edge.
- R9: Reads return the following. Offsets 0x14 to 0x2c (step 4) give the calendar read-back fields. Offsets 0x30 to 0x48 give the committed alarm. The keys and the configuration registers give committed values. Offset 0x70 gives the staged protection word. Offset 0x00 gives busy in bit 6. All other offsets and bits read 0.
- R10: The seven time and alarm fields, in offset order, are second, minute, hour, day of month, day of week, month and year. They are 6, 6, 5, 5, 3, 4 and 7 bits wide, and writes and read-back are masked to these widths. Field i occupies bits 7i+6:7i of `time_o`, `alarm_o` and `cal_time_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cal_time_i | input | 49 | Live time from the calendar counter, seven 7-bit fields |
| time_o | output | 49 | Committed time for the calendar counter |
| time_load_o | output | 1 | One-cycle strobe when time_o takes a new commit |
| alarm_o | output | 49 | Committed alarm value |
| cfg_a_o | output | 16 | Committed configuration register at 0x5c |
| cfg_b_o | output | 16 | Committed configuration register at 0x60 |
| reload_o | output | 1 | One-cycle reload request |
| busy_o | output | 1 | Commit in progress |
| unlocked_o | output | 1 | Write protection open |
| power_lost_o | output | 1 | Power keys not valid |

## Verification
Two pairs of events can fall on the same clock edge. In the first, a staging write to a time field lands on the edge that ends a commit. The bench places the write exactly COMMIT_CYCLES edges after the trigger and expects the old field value on `time_o`, with the new value appearing only after a second commit. In the second, a key-clearing control write lands on the edge where a key commit completes. The bench expects `power_lost_o` to stay 1, because the clear must win. A behavioural model in the bench judges every cycle of both cases, and explicit checks are added at each of these points.

// File: rtl/rtc_commit_pkg.sv
`timescale 1ns/1ps
package rtc_commit_pkg;

  localparam int unsigned NFIELD  = 7;
  localparam int unsigned FIELD_W = 7;
  localparam int unsigned ADDR_W  = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TIME0 = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ALM0  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_KEY_A = 8'h4c;
  localparam logic [ADDR_W-1:0] OFS_KEY_B = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_CFG_A = 8'h5c;
  localparam logic [ADDR_W-1:0] OFS_CFG_B = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_PROT  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h78;

  localparam logic [15:0] KEY_A_VAL = 16'ha357;
  localparam logic [15:0] KEY_B_VAL = 16'h67d2;
  localparam logic [15:0] UNLOCK_W1 = 16'h9136;
  localparam logic [15:0] UNLOCK_W2 = 16'h586a;
  localparam logic [7:0]  CTRL_PASS = 8'h43;

  localparam int unsigned BUSY_BIT   = 6;
  localparam int unsigned RELOAD_BIT = 5;
  localparam int unsigned CLRKEY_BIT = 4;

  typedef enum logic [1:0] {
    WP_LOCKED = 2'd0,
    WP_HALF   = 2'd1,
    WP_OPEN   = 2'd2
  } wp_state_e;

  // width mask of each calendar field, in offset order
  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 7'h3f;
      2, 3:    field_mask = 7'h1f;
      4:       field_mask = 7'h07;
      5:       field_mask = 7'h0f;
      default: field_mask = 7'h7f;
    endcase
  endfunction

endpackage

// File: rtl/rtc_commit_seq.sv
`timescale 1ns/1ps
module rtc_commit_seq #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic busy,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_ONE;
      cnt_en = 1'b1;
    end else if (start_req) begin
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_ONE);

endmodule

// File: rtl/rtc_wprot_fsm.sv
`timescale 1ns/1ps
module rtc_wprot_fsm
  import rtc_commit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit_done,
  input  logic        word_dirty,
  input  logic [15:0] word,
  output logic        open
);

  wp_state_e state_q, state_d;
  logic      state_en;

  always_comb begin
    state_d  = state_q;
    state_en = commit_done && word_dirty;
    if (word == UNLOCK_W1) begin
      state_d = WP_HALF;
    end else if (word == UNLOCK_W2 && state_q == WP_HALF) begin
      state_d = WP_OPEN;
    end else begin
      state_d = WP_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WP_LOCKED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign open = (state_q == WP_OPEN);

endmodule

// File: rtl/rtc_pkey_check.sv
`timescale 1ns/1ps
module rtc_pkey_check
  import rtc_commit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit_done,
  input  logic        cfg_seen_all,
  input  logic        clear_req,
  input  logic [15:0] key_a_stg,
  input  logic [15:0] key_b_stg,
  output logic [15:0] key_a_q,
  output logic [15:0] key_b_q,
  output logic        power_lost
);

  logic [15:0] key_a_d, key_b_d;
  logic        cfg_ok_q, cfg_ok_d;

  always_comb begin
    key_a_d  = key_a_q;
    key_b_d  = key_b_q;
    cfg_ok_d = cfg_ok_q;
    if (commit_done) begin
      if (cfg_ok_q) begin
        key_a_d = key_a_stg;
        key_b_d = key_b_stg;
      end
      if (cfg_seen_all) begin
        cfg_ok_d = 1'b1;
      end
    end
    if (clear_req) begin
      key_a_d = '0;
      key_b_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a_q  <= '0;
      key_b_q  <= '0;
      cfg_ok_q <= 1'b0;
    end else begin
      key_a_q  <= key_a_d;
      key_b_q  <= key_b_d;
      cfg_ok_q <= cfg_ok_d;
    end
  end

  assign power_lost = !((key_a_q == KEY_A_VAL) && (key_b_q == KEY_B_VAL));

endmodule

// File: rtl/rtc_commit_unit.sv
`timescale 1ns/1ps
module rtc_commit_unit
  import rtc_commit_pkg::*;
#(
  parameter int unsigned COMMIT_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [48:0] cal_time_i,
  output logic [48:0] time_o,
  output logic        time_load_o,
  output logic [48:0] alarm_o,
  output logic [15:0] cfg_a_o,
  output logic [15:0] cfg_b_o,
  output logic        reload_o,
  output logic        busy_o,
  output logic        unlocked_o,
  output logic        power_lost_o
);

  localparam int unsigned TBUS_W = NFIELD * FIELD_W;

  logic commit_done, commit_busy, trig_req;
  logic ctl_pass, clr_keys;
  logic wp_open;

  logic [TBUS_W-1:0] rd_time_flat, rd_alm_flat;
  logic [NFIELD-1:0] t_hit, a_hit;

  logic [15:0] cfg_a_stg_q, cfg_a_stg_d, cfg_b_stg_q, cfg_b_stg_d;
  logic [15:0] cfg_a_com_q, cfg_a_com_d, cfg_b_com_q, cfg_b_com_d;
  logic [1:0]  cfg_seen_q, cfg_seen_d;
  logic [15:0] key_a_stg_q, key_a_stg_d, key_b_stg_q, key_b_stg_d;
  logic [15:0] key_a_com, key_b_com;
  logic [15:0] prot_q, prot_d;
  logic        prot_dirty_q, prot_dirty_d;
  logic        tload_q, tload_d;
  logic        reload_q, reload_d;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata[31:16];

  // bus decode
  assign trig_req = bus_wr && (bus_addr == OFS_TRIG) && bus_wdata[0];
  assign ctl_pass = bus_wr && (bus_addr == OFS_CTRL) && (bus_wdata[15:8] == CTRL_PASS);
  assign clr_keys = ctl_pass && bus_wdata[CLRKEY_BIT];

  rtc_commit_seq #(.CYCLES(COMMIT_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (trig_req),
    .busy      (commit_busy),
    .done      (commit_done)
  );

  rtc_wprot_fsm u_wprot (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_done (commit_done),
    .word_dirty  (prot_dirty_q),
    .word        (prot_q),
    .open        (wp_open)
  );

  rtc_pkey_check u_pkey (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_done  (commit_done),
    .cfg_seen_all (&cfg_seen_q),
    .clear_req    (clr_keys),
    .key_a_stg    (key_a_stg_q),
    .key_b_stg    (key_b_stg_q),
    .key_a_q      (key_a_com),
    .key_b_q      (key_b_com),
    .power_lost   (power_lost_o)
  );

  // calendar and alarm fields, one slice per field
  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
    localparam logic [ADDR_W-1:0]  T_OFS = OFS_TIME0 + ADDR_W'(4 * gi);
    localparam logic [ADDR_W-1:0]  A_OFS = OFS_ALM0 + ADDR_W'(4 * gi);
    localparam logic [FIELD_W-1:0] MSK   = field_mask(gi);

    logic [FIELD_W-1:0] stg_t_q, stg_t_d, stg_a_q, stg_a_d;
    logic [FIELD_W-1:0] com_t_q, com_t_d, com_a_q, com_a_d;

    always_comb begin
      stg_t_d = stg_t_q;
      stg_a_d = stg_a_q;
      com_t_d = com_t_q;
      com_a_d = com_a_q;
      if (bus_wr && bus_addr == T_OFS) stg_t_d = bus_wdata[FIELD_W-1:0] & MSK;
      if (bus_wr && bus_addr == A_OFS) stg_a_d = bus_wdata[FIELD_W-1:0] & MSK;
      if (commit_done && wp_open) begin
        com_t_d = stg_t_q;
        com_a_d = stg_a_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_t_q <= '0;
        stg_a_q <= '0;
        com_t_q <= '0;
        com_a_q <= '0;
      end else begin
        stg_t_q <= stg_t_d;
        stg_a_q <= stg_a_d;
        com_t_q <= com_t_d;
        com_a_q <= com_a_d;
      end
    end

    assign time_o[gi*FIELD_W +: FIELD_W]       = com_t_q;
    assign alarm_o[gi*FIELD_W +: FIELD_W]      = com_a_q;
    assign rd_time_flat[gi*FIELD_W +: FIELD_W] = cal_time_i[gi*FIELD_W +: FIELD_W] & MSK;
    assign rd_alm_flat[gi*FIELD_W +: FIELD_W]  = com_a_q;
    assign t_hit[gi] = (bus_addr == T_OFS);
    assign a_hit[gi] = (bus_addr == A_OFS);
  end

  // configuration, key, protection and strobe next state
  always_comb begin
    cfg_a_stg_d  = cfg_a_stg_q;
    cfg_b_stg_d  = cfg_b_stg_q;
    cfg_seen_d   = cfg_seen_q;
    key_a_stg_d  = key_a_stg_q;
    key_b_stg_d  = key_b_stg_q;
    prot_d       = prot_q;
    prot_dirty_d = prot_dirty_q;
    cfg_a_com_d  = commit_done ? cfg_a_stg_q : cfg_a_com_q;
    cfg_b_com_d  = commit_done ? cfg_b_stg_q : cfg_b_com_q;
    tload_d      = commit_done && wp_open;
    reload_d     = ctl_pass && bus_wdata[RELOAD_BIT];

    if (commit_done) prot_dirty_d = 1'b0;

    if (bus_wr) begin
      case (bus_addr)
        OFS_CFG_A: begin
          cfg_a_stg_d   = bus_wdata[15:0];
          cfg_seen_d[0] = 1'b1;
        end
        OFS_CFG_B: begin
          cfg_b_stg_d   = bus_wdata[15:0];
          cfg_seen_d[1] = 1'b1;
        end
        OFS_KEY_A: key_a_stg_d = bus_wdata[15:0];
        OFS_KEY_B: key_b_stg_d = bus_wdata[15:0];
        OFS_PROT: begin
          prot_d       = bus_wdata[15:0];
          prot_dirty_d = 1'b1;
        end
        default: ;
      endcase
    end

    if (clr_keys) begin
      key_a_stg_d = '0;
      key_b_stg_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_stg_q  <= '0;
      cfg_b_stg_q  <= '0;
      cfg_a_com_q  <= '0;
      cfg_b_com_q  <= '0;
      cfg_seen_q   <= '0;
      key_a_stg_q  <= '0;
      key_b_stg_q  <= '0;
      prot_q       <= '0;
      prot_dirty_q <= 1'b0;
      tload_q      <= 1'b0;
      reload_q     <= 1'b0;
    end else begin
      cfg_a_stg_q  <= cfg_a_stg_d;
      cfg_b_stg_q  <= cfg_b_stg_d;
      cfg_a_com_q  <= cfg_a_com_d;
      cfg_b_com_q  <= cfg_b_com_d;
      cfg_seen_q   <= cfg_seen_d;
      key_a_stg_q  <= key_a_stg_d;
      key_b_stg_q  <= key_b_stg_d;
      prot_q       <= prot_d;
      prot_dirty_q <= prot_dirty_d;
      tload_q      <= tload_d;
      reload_q     <= reload_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:  bus_rdata[BUSY_BIT] = commit_busy;
      OFS_KEY_A: bus_rdata[15:0] = key_a_com;
      OFS_KEY_B: bus_rdata[15:0] = key_b_com;
      OFS_CFG_A: bus_rdata[15:0] = cfg_a_com_q;
      OFS_CFG_B: bus_rdata[15:0] = cfg_b_com_q;
      OFS_PROT:  bus_rdata[15:0] = prot_q;
      default: ;
    endcase
    for (int i = 0; i < NFIELD; i++) begin
      if (t_hit[i]) bus_rdata[FIELD_W-1:0] = rd_time_flat[i*FIELD_W +: FIELD_W];
      if (a_hit[i]) bus_rdata[FIELD_W-1:0] = rd_alm_flat[i*FIELD_W +: FIELD_W];
    end
  end

  assign busy_o      = commit_busy;
  assign unlocked_o  = wp_open;
  assign time_load_o = tload_q;
  assign reload_o    = reload_q;
  assign cfg_a_o     = cfg_a_com_q;
  assign cfg_b_o     = cfg_b_com_q;

endmodule

// File: rtl/rtc_commit_unit_chk.sv
`timescale 1ns/1ps
module rtc_commit_unit_chk
  import rtc_commit_pkg::*;
#(
  parameter int unsigned COMMIT_CYCLES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [48:0] time_o,
  input logic        time_load_o,
  input logic        reload_o,
  input logic        busy_o,
  input logic        unlocked_o,
  input logic        power_lost_o
);

  localparam int unsigned LEN_W = $clog2(COMMIT_CYCLES + 1) + 1;

  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
    end else if (busy_o) begin
      busy_len <= busy_len + LEN_W'(1);
    end else begin
      busy_len <= '0;
    end
  end

  AST_BUSY_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(bus_wr && bus_addr == OFS_TRIG && bus_wdata[0])); // R1

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len == LEN_W'(COMMIT_CYCLES))); // R2

  AST_UNLOCK_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $fell(busy_o)); // R4

  AST_RELOCK_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked_o) |-> $fell(busy_o)); // R5

  AST_LOAD_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    time_load_o |-> ($fell(busy_o) && $past(unlocked_o))); // R6

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !time_load_o |-> $stable(time_o)); // R6

  AST_POWER_OK_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_lost_o) |-> $fell(busy_o)); // R7

  AST_RELOAD_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |-> $past(bus_wr && bus_addr == OFS_CTRL &&
                       bus_wdata[15:8] == CTRL_PASS && bus_wdata[RELOAD_BIT])); // R8

  AST_CTRL_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[BUSY_BIT] == busy_o)); // R9

endmodule

bind rtc_commit_unit rtc_commit_unit_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .time_o       (time_o),
  .time_load_o  (time_load_o),
  .reload_o     (reload_o),
  .busy_o       (busy_o),
  .unlocked_o   (unlocked_o),
  .power_lost_o (power_lost_o)
);

// File: tb/rtc_commit_unit_tb.sv
`timescale 1ns/1ps
module rtc_commit_unit_tb;

  localparam int CYC = 8;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [48:0] cal_time_i;
  logic [48:0] time_o;
  logic        time_load_o;
  logic [48:0] alarm_o;
  logic [15:0] cfg_a_o;
  logic [15:0] cfg_b_o;
  logic        reload_o;
  logic        busy_o;
  logic        unlocked_o;
  logic        power_lost_o;

  int vectors = 0;
  int miscompares = 0;

  rtc_commit_unit #(.COMMIT_CYCLES(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cal_time_i(cal_time_i),
    .time_o(time_o), .time_load_o(time_load_o), .alarm_o(alarm_o),
    .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o), .reload_o(reload_o),
    .busy_o(busy_o), .unlocked_o(unlocked_o), .power_lost_o(power_lost_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mmask [7] = '{63, 63, 31, 31, 7, 15, 127};
  int m_cnt, m_wp, m_prot, m_prot_pend, m_cfg_ok, m_reload, m_tload;
  int m_stg_t [7];
  int m_com_t [7];
  int m_stg_a [7];
  int m_com_a [7];
  int m_cfg_stg [2];
  int m_cfg_com [2];
  int m_seen [2];
  int m_key_stg [2];
  int m_key_com [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_wp = 0; m_prot = 0; m_prot_pend = 0; m_cfg_ok = 0;
      m_reload = 0; m_tload = 0;
      for (int i = 0; i < 7; i++) begin
        m_stg_t[i] = 0; m_com_t[i] = 0; m_stg_a[i] = 0; m_com_a[i] = 0;
      end
      for (int j = 0; j < 2; j++) begin
        m_cfg_stg[j] = 0; m_cfg_com[j] = 0; m_seen[j] = 0;
        m_key_stg[j] = 0; m_key_com[j] = 0;
      end
    end else begin
      automatic bit finishing = (m_cnt == 1);
      automatic bit was_open  = (m_wp == 2);
      automatic bit ok_before = (m_cfg_ok != 0);
      automatic int a = int'(bus_addr);
      automatic int d = int'(bus_wdata[15:0]);
      m_tload = (finishing && was_open) ? 1 : 0;
      if (finishing) begin
        if (was_open) begin
          for (int i = 0; i < 7; i++) begin
            m_com_t[i] = m_stg_t[i];
            m_com_a[i] = m_stg_a[i];
          end
        end
        m_cfg_com[0] = m_cfg_stg[0];
        m_cfg_com[1] = m_cfg_stg[1];
        if (m_seen[0] != 0 && m_seen[1] != 0) m_cfg_ok = 1;
        if (ok_before) begin
          m_key_com[0] = m_key_stg[0];
          m_key_com[1] = m_key_stg[1];
        end
        if (m_prot_pend != 0) begin
          if (m_prot == 'h9136) m_wp = 1;
          else if (m_prot == 'h586a && m_wp == 1) m_wp = 2;
          else m_wp = 0;
        end
        m_prot_pend = 0;
      end
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      else if (bus_wr && a == 'h78 && bus_wdata[0]) m_cnt = CYC;
      m_reload = 0;
      if (bus_wr) begin
        if (a == 0 && bus_wdata[15:8] == 8'h43) begin
          m_reload = bus_wdata[5] ? 1 : 0;
          if (bus_wdata[4]) begin
            m_key_com[0] = 0; m_key_com[1] = 0;
            m_key_stg[0] = 0; m_key_stg[1] = 0;
          end
        end
        for (int i = 0; i < 7; i++) begin
          if (a == 'h14 + 4 * i) m_stg_t[i] = int'(bus_wdata[6:0]) & mmask[i];
          if (a == 'h30 + 4 * i) m_stg_a[i] = int'(bus_wdata[6:0]) & mmask[i];
        end
        if (a == 'h5c) begin m_cfg_stg[0] = d; m_seen[0] = 1; end
        if (a == 'h60) begin m_cfg_stg[1] = d; m_seen[1] = 1; end
        if (a == 'h4c) m_key_stg[0] = d;
        if (a == 'h50) m_key_stg[1] = d;
        if (a == 'h70) begin m_prot = d; m_prot_pend = 1; end
      end
    end
  end

  function automatic logic [48:0] pack7(input int f [7]);
    logic [48:0] r = '0;
    for (int i = 0; i < 7; i++) r[i*7 +: 7] = 7'(f[i]);
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] ad);
    logic [31:0] r = '0;
    int a = int'(ad);
    if (a == 0) r[6] = (m_cnt != 0);
    if (a == 'h4c) r[15:0] = 16'(m_key_com[0]);
    if (a == 'h50) r[15:0] = 16'(m_key_com[1]);
    if (a == 'h5c) r[15:0] = 16'(m_cfg_com[0]);
    if (a == 'h60) r[15:0] = 16'(m_cfg_com[1]);
    if (a == 'h70) r[15:0] = 16'(m_prot);
    for (int i = 0; i < 7; i++) begin
      if (a == 'h14 + 4 * i) r[6:0] = cal_time_i[i*7 +: 7] & 7'(mmask[i]);
      if (a == 'h30 + 4 * i) r[6:0] = 7'(m_com_a[i]);
    end
    return r;
  endfunction

  task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp(64'(busy_o), 64'(m_cnt != 0), "R2 busy_o");
      cmp(64'(unlocked_o), 64'(m_wp == 2), "R4/R5 unlocked_o");
      cmp(64'(power_lost_o),
          64'(!(m_key_com[0] == 'ha357 && m_key_com[1] == 'h67d2)), "R7 power_lost_o");
      cmp(64'(time_load_o), 64'(m_tload), "R6 time_load_o");
      cmp(64'(time_o), 64'(pack7(m_com_t)), "R3/R6 time_o");
      cmp(64'(alarm_o), 64'(pack7(m_com_a)), "R6 alarm_o");
      cmp(64'(reload_o), 64'(m_reload), "R8 reload_o");
      cmp(64'({cfg_a_o, cfg_b_o}), 64'({16'(m_cfg_com[0]), 16'(m_cfg_com[1])}), "R7 cfg outputs");
      cmp(64'(bus_rdata), 64'(exp_rd(bus_addr)), "R9 bus_rdata");
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic commit();
    wr(8'h78, 32'h1);
    idle(CYC + 1);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cal_time_i = 49'h0_1234_5678_9abc;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    cmp(64'(power_lost_o), 64'd1, "R7 reset power_lost_o");
    cmp(64'(busy_o), 64'd0, "R2 reset busy_o");
    cmp(64'(unlocked_o), 64'd0, "R4 reset unlocked_o");

    // locked commit keeps time and alarm
    wr(8'h14, 32'h15); wr(8'h30, 32'h22);
    commit();
    cmp(64'(time_o), 64'd0, "R6 locked time_o");
    cmp(64'(alarm_o), 64'd0, "R6 locked alarm_o");

    // trigger rules
    wr(8'h78, 32'h0); idle(1);
    cmp(64'(busy_o), 64'd0, "R1 trigger bit0 clear");
    wr(8'h78, 32'h1); idle(3);
    wr(8'h78, 32'h1);
    idle(CYC + 2);
    cmp(64'(busy_o), 64'd0, "R1 trigger while busy ignored");

    // control key byte
    wr(8'h00, 32'h0000_4220);
    cmp(64'(reload_o), 64'd0, "R8 reload without key byte");
    wr(8'h00, 32'h0000_4320);
    cmp(64'(reload_o), 64'd1, "R8 reload with key byte");

    // keys before configuration are not taken
    wr(8'h4c, 32'ha357); wr(8'h50, 32'h67d2);
    wr(8'h5c, 32'h4848); wr(8'h60, 32'h0048);
    commit();
    cmp(64'(power_lost_o), 64'd1, "R7 keys before cfg commit");
    commit();
    cmp(64'(power_lost_o), 64'd0, "R7 keys after cfg commit");
    bus_addr = 8'h4c; #1;
    cmp(64'(bus_rdata), 64'h0000a357, "R9 key read");

    // unlock sequence, wrong orders first
    wr(8'h70, 32'h586a); commit();
    cmp(64'(unlocked_o), 64'd0, "R5 second word first");
    wr(8'h70, 32'h9136); commit();
    wr(8'h70, 32'h1234); commit();
    cmp(64'(unlocked_o), 64'd0, "R5 other word between");
    wr(8'h70, 32'h9136); commit();
    cmp(64'(unlocked_o), 64'd0, "R4 half step");
    wr(8'h70, 32'h586a); commit();
    cmp(64'(unlocked_o), 64'd1, "R4 unlocked");
    commit();
    cmp(64'(unlocked_o), 64'd1, "R5 commit without prot write keeps state");

    // masked fields
    for (int i = 0; i < 7; i++) begin
      wr(8'(8'h14 + 4 * i), 32'hff);
      wr(8'(8'h30 + 4 * i), 32'h55 + i);
    end
    commit();
    cmp(64'(time_o), 64'(pack7('{63, 63, 31, 31, 7, 15, 127})), "R10 time_o masked");

    // staging write on the completing edge
    wr(8'h14, 32'h05); commit();
    wr(8'h78, 32'h1); idle(CYC - 1);
    wr(8'h14, 32'h09);
    idle(2);
    cmp(64'(time_o[6:0]), 64'h05, "R3 old value transferred");
    commit();
    cmp(64'(time_o[6:0]), 64'h09, "R3 new value on next commit");

    // read sweep with two calendar patterns
    for (int p = 0; p < 2; p++) begin
      cal_time_i = (p == 0) ? 49'h1_ffff_ffff_ffff : 49'h0_a5a5_5a5a_3c3c;
      for (int a = 0; a < 'h80; a += 4) begin
        bus_addr = 8'(a); idle(1);
      end
    end
    bus_addr = 8'h00;

    // clear colliding with the completing key commit
    wr(8'h78, 32'h1); idle(CYC - 1);
    wr(8'h00, 32'h0000_4310);
    idle(2);
    cmp(64'(power_lost_o), 64'd1, "R8 clear wins over commit");
    wr(8'h4c, 32'ha357); wr(8'h50, 32'h67d2); commit();
    cmp(64'(power_lost_o), 64'd0, "R7 keys restored");
    wr(8'h00, 32'h0000_4210); idle(1);
    cmp(64'(power_lost_o), 64'd0, "R8 clear without key byte ignored");

    // relock
    wr(8'h70, 32'h0); commit();
    cmp(64'(unlocked_o), 64'd0, "R5 relock on other word");
    wr(8'h14, 32'h11); commit();
    cmp(64'(time_o[6:0]), 64'h09, "R6 relocked time kept");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule